// File: doc/BRIEF.md
# Framed Byte-Stream Packet Parser with CRC-8

This block sits behind a serial receiver and watches the received byte stream, one byte per cycle when the valid strobe is high. It looks for a fixed two-byte start signature. It then takes a command byte and a length byte, then as many payload bytes as the length says. After that it expects one check byte and a fixed two-byte end signature. The command byte and each payload byte come out on their own valid-qualified ports one cycle after they are accepted. A packet that closes cleanly produces a one-cycle done pulse. A packet that breaks produces a one-cycle error pulse with a code that tells what went wrong.

The check byte is a CRC-8. Its polynomial is x^8+x^2+x+1 (0x07), it starts from zero, it shifts most significant bit first, and it covers the command, the length and every payload byte. After any error the parser goes back to hunting for the start signature. Bytes that arrive while no packet is open are dropped without any output.

Top module: `pkt_parser`

## Requirements
- R1: While reset is asserted and after it is released, cmd_valid, pl_valid, done and err_valid are all low and err_code is 0.
- R2: The parser opens a packet only on byte 0xAB followed directly by byte 0xCD. While it waits for 0xAB, any other byte produces no output at all.
- R3: If the byte after 0xAB is not 0xCD, err_valid pulses with err_code 1 in the next cycle. If that byte is itself 0xAB, the parser stays armed, so a following 0xCD opens a packet. Any other byte sends it back to waiting for 0xAB.
- R4: The byte after the start signature is the command. In the next cycle cmd_valid pulses and cmd_byte carries that byte.
- R5: The byte after the command is the length N (0 to 255). The next N accepted bytes each come out on pl_byte, with pl_valid pulsing one cycle after each one is accepted.
- R6: A length of 0 produces no payload output, and the very next byte is taken as the check byte.
- R7: The check byte must equal the CRC-8 (polynomial 0x07, initial 0x00, MSB first, no final XOR) of the command, length and payload bytes. On a mismatch, err_valid pulses with err_code 2, no done follows, and the parser returns to waiting for 0xAB.
- R8: After the check byte the parser expects 0xE1 and then 0xE2. If either one differs, err_valid pulses with err_code 3, no done follows, and the parser returns to waiting for 0xAB.
- R9: When a packet completes with a correct check byte and a correct end signature, done pulses for one cycle, in the cycle after 0xE2 is accepted. Done and err_valid are never high together.
- R10: A cycle with in_valid low advances nothing. In the following cycle all four output strobes are low.
- R11: A packet with the largest length, 255, delivers all 255 payload bytes in order and completes with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_byte carries a received byte this cycle |
| in_byte | input | 8 | Received byte |
| cmd_valid | output | 1 | One-cycle strobe: cmd_byte is new |
| cmd_byte | output | 8 | Command byte of the open packet |
| pl_valid | output | 1 | One-cycle strobe: pl_byte is a payload byte |
| pl_byte | output | 8 | Payload byte |
| done | output | 1 | One-cycle strobe: a packet closed without error |
| err_valid | output | 1 | One-cycle strobe: a packet or start signature failed |
| err_code | output | 2 | 1 bad start signature, 2 bad CRC, 3 bad end signature, 0 otherwise |

## Verification
The stream is tried in several forms. A clean packet preceded by noise bytes separates correct signature hunting from opening a packet on any byte. A doubled 0xAB before 0xCD separates re-arming from a plain fall-back to the hunt. Zero-length and 255-length packets probe both ends of the payload counter. Packets with a flipped check byte or a wrong first or second end byte confirm that each fault gives its own code and that no done follows. Idle gaps placed inside a packet show that progress depends only on the valid strobe.

// File: rtl/pkt_parser_pkg.sv
package pkt_parser_pkg;

   typedef enum logic [2:0] {
      ST_SYNC0 = 3'd0,
      ST_SYNC1 = 3'd1,
      ST_CMD   = 3'd2,
      ST_LEN   = 3'd3,
      ST_PAY   = 3'd4,
      ST_CHK   = 3'd5,
      ST_END0  = 3'd6,
      ST_END1  = 3'd7
   } pkt_state_t;

   typedef enum logic [1:0] {
      ERR_NONE = 2'd0,
      ERR_SYNC = 2'd1,
      ERR_CRC  = 2'd2,
      ERR_END  = 2'd3
   } pkt_err_t;

endpackage

// File: rtl/pkt_crc8.sv
module pkt_crc8 #(
   parameter int          W         = 8,
   parameter logic [W-1:0] POLY     = 8'h07,
   parameter logic [W-1:0] INIT     = 8'h00,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         upd,
   input  logic [W-1:0] din,
   output logic [W-1:0] crc
);

   logic [W-1:0] nxt;

   generate
      if (W < 2) begin : g_bad_w
         $error("pkt_crc8: W must be at least 2");
      end

      if (MSB_FIRST) begin : g_msb
         always_comb begin
            logic [W-1:0] r;
            r = crc ^ din;
            for (int i = 0; i < W; i++) begin
               if (r[W-1]) r = {r[W-2:0], 1'b0} ^ POLY;
               else        r = {r[W-2:0], 1'b0};
            end
            nxt = r;
         end
      end else begin : g_lsb
         logic [W-1:0] poly_rev;
         always_comb begin
            for (int i = 0; i < W; i++) poly_rev[i] = POLY[W-1-i];
         end
         always_comb begin
            logic [W-1:0] r;
            r = crc ^ din;
            for (int i = 0; i < W; i++) begin
               if (r[0]) r = {1'b0, r[W-1:1]} ^ poly_rev;
               else      r = {1'b0, r[W-1:1]};
            end
            nxt = r;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= INIT;
      else if (clr) crc <= INIT;
      else if (upd) crc <= nxt;
   end

   // R7: a clear always lands on the initial value
   p_clear_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (crc == INIT));

endmodule

// File: rtl/pkt_len_cnt.sv
module pkt_len_cnt #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             dec,
   output logic [LEN_W-1:0] remain,
   output logic             last
);

   generate
      if (LEN_W < 1) begin : g_bad_len
         $error("pkt_len_cnt: LEN_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    remain <= '0;
      else if (load) remain <= load_val;
      else if (dec)  remain <= remain - 1'b1;
   end

   assign last = (remain == {{(LEN_W-1){1'b0}}, 1'b1});

   // R5: the payload count never wraps below zero
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (remain != '0));

endmodule

// File: rtl/pkt_parser.sv
module pkt_parser
   import pkt_parser_pkg::*;
#(
   parameter int             DATA_W    = 8,
   parameter int             LEN_W     = 8,
   parameter logic [7:0]     SYNC0     = 8'hAB,
   parameter logic [7:0]     SYNC1     = 8'hCD,
   parameter logic [7:0]     END0      = 8'hE1,
   parameter logic [7:0]     END1      = 8'hE2,
   parameter logic [7:0]     CRC_POLY  = 8'h07,
   parameter logic [7:0]     CRC_INIT  = 8'h00,
   parameter bit             CRC_MSB_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [7:0]  in_byte,
   output logic        cmd_valid,
   output logic [7:0]  cmd_byte,
   output logic        pl_valid,
   output logic [7:0]  pl_byte,
   output logic        done,
   output logic        err_valid,
   output logic [1:0]  err_code
);

   localparam int MAX_LEN = (1 << LEN_W) - 1;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("pkt_parser: DATA_W must be 8");
      end
      if (LEN_W > DATA_W) begin : g_bad_lenw
         $error("pkt_parser: LEN_W cannot exceed DATA_W");
      end
      if (MAX_LEN < 1) begin : g_bad_max
         $error("pkt_parser: length range empty");
      end
   endgenerate

   pkt_state_t       st_q, st_d;
   logic             crc_clr, crc_upd;
   logic [7:0]       crc_val;
   logic             cnt_load, cnt_dec, cnt_last;
   logic [LEN_W-1:0] cnt_rem;

   logic             cmd_v_d, pl_v_d, done_d, err_v_d;
   pkt_err_t         err_c_d;

   pkt_crc8 #(
      .W         (8),
      .POLY      (CRC_POLY),
      .INIT      (CRC_INIT),
      .MSB_FIRST (CRC_MSB_FIRST)
   ) i_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .upd   (crc_upd),
      .din   (in_byte),
      .crc   (crc_val)
   );

   pkt_len_cnt #(
      .LEN_W (LEN_W)
   ) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (in_byte[LEN_W-1:0]),
      .dec      (cnt_dec),
      .remain   (cnt_rem),
      .last     (cnt_last)
   );

   always_comb begin
      st_d     = st_q;
      crc_clr  = 1'b0;
      crc_upd  = 1'b0;
      cnt_load = 1'b0;
      cnt_dec  = 1'b0;
      cmd_v_d  = 1'b0;
      pl_v_d   = 1'b0;
      done_d   = 1'b0;
      err_v_d  = 1'b0;
      err_c_d  = ERR_NONE;
      if (in_valid) begin
         unique case (st_q)
            ST_SYNC0: begin
               if (in_byte == SYNC0) st_d = ST_SYNC1;
            end
            ST_SYNC1: begin
               if (in_byte == SYNC1) begin
                  st_d    = ST_CMD;
                  crc_clr = 1'b1;
               end else begin
                  err_v_d = 1'b1;
                  err_c_d = ERR_SYNC;
                  st_d    = (in_byte == SYNC0) ? ST_SYNC1 : ST_SYNC0;
               end
            end
            ST_CMD: begin
               cmd_v_d = 1'b1;
               crc_upd = 1'b1;
               st_d    = ST_LEN;
            end
            ST_LEN: begin
               crc_upd  = 1'b1;
               cnt_load = 1'b1;
               st_d     = (in_byte[LEN_W-1:0] == '0) ? ST_CHK : ST_PAY;
            end
            ST_PAY: begin
               pl_v_d  = 1'b1;
               crc_upd = 1'b1;
               cnt_dec = 1'b1;
               if (cnt_last) st_d = ST_CHK;
            end
            ST_CHK: begin
               if (in_byte == crc_val) begin
                  st_d = ST_END0;
               end else begin
                  err_v_d = 1'b1;
                  err_c_d = ERR_CRC;
                  st_d    = ST_SYNC0;
               end
            end
            ST_END0: begin
               if (in_byte == END0) begin
                  st_d = ST_END1;
               end else begin
                  err_v_d = 1'b1;
                  err_c_d = ERR_END;
                  st_d    = ST_SYNC0;
               end
            end
            ST_END1: begin
               if (in_byte == END1) begin
                  done_d = 1'b1;
               end else begin
                  err_v_d = 1'b1;
                  err_c_d = ERR_END;
               end
               st_d = ST_SYNC0;
            end
            default: st_d = ST_SYNC0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_SYNC0;
         cmd_valid <= 1'b0;
         cmd_byte  <= '0;
         pl_valid  <= 1'b0;
         pl_byte   <= '0;
         done      <= 1'b0;
         err_valid <= 1'b0;
         err_code  <= ERR_NONE;
      end else begin
         st_q      <= st_d;
         cmd_valid <= cmd_v_d;
         pl_valid  <= pl_v_d;
         done      <= done_d;
         err_valid <= err_v_d;
         err_code  <= err_c_d;
         if (cmd_v_d) cmd_byte <= in_byte;
         if (pl_v_d)  pl_byte  <= in_byte;
      end
   end

   // R9: success and failure never share a cycle
   p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err_valid));

   // R9: done is a single-cycle pulse
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: an idle input cycle yields no output strobe
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !(cmd_valid || pl_valid || done || err_valid));

   // R3: an error strobe always carries a nonzero code
   p_err_coded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> (err_code != 2'd0));

   // R4: at most one kind of strobe per cycle
   p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_valid, pl_valid, done, err_valid}));

endmodule

// File: tb/test_pkt_parser.sv
module test_pkt_parser;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       cmd_valid, pl_valid, done, err_valid;
   logic [7:0] cmd_byte, pl_byte;
   logic [1:0] err_code;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R1";
   bit cmp_en = 1'b0;

   always #2 clk = ~clk;

   pkt_parser i_pkt_parser (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_byte   (in_byte),
      .cmd_valid (cmd_valid),
      .cmd_byte  (cmd_byte),
      .pl_valid  (pl_valid),
      .pl_byte   (pl_byte),
      .done      (done),
      .err_valid (err_valid),
      .err_code  (err_code)
   );

   // bitwise serial CRC-8, polynomial 0x07, MSB first
   function automatic logic [7:0] crc_add(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] r;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         logic fb;
         fb = r[7] ^ d[i];
         r = {r[6:0], 1'b0};
         if (fb) r = r ^ 8'h07;
      end
      return r;
   endfunction

   // reference model
   int         m_ph = 0;
   int         m_left = 0;
   logic [7:0] m_crc = 8'h00;
   logic       e_cmd_v = 0, e_pl_v = 0, e_done = 0, e_err_v = 0;
   logic [7:0] e_cmd = 0, e_pl = 0;
   logic [1:0] e_code = 0;

   always @(posedge clk) begin
      e_cmd_v = 0; e_pl_v = 0; e_done = 0; e_err_v = 0; e_code = 0;
      if (rst_n && in_valid) begin
         case (m_ph)
            0: if (in_byte == 8'hAB) m_ph = 1;
            1: if (in_byte == 8'hCD) begin m_ph = 2; m_crc = 8'h00; end
               else begin e_err_v = 1; e_code = 1; m_ph = (in_byte == 8'hAB) ? 1 : 0; end
            2: begin e_cmd_v = 1; e_cmd = in_byte; m_crc = crc_add(m_crc, in_byte); m_ph = 3; end
            3: begin m_crc = crc_add(m_crc, in_byte); m_left = in_byte; m_ph = (m_left == 0) ? 5 : 4; end
            4: begin e_pl_v = 1; e_pl = in_byte; m_crc = crc_add(m_crc, in_byte);
                  m_left--; if (m_left == 0) m_ph = 5; end
            5: if (in_byte == m_crc) m_ph = 6;
               else begin e_err_v = 1; e_code = 2; m_ph = 0; end
            6: if (in_byte == 8'hE1) m_ph = 7;
               else begin e_err_v = 1; e_code = 3; m_ph = 0; end
            default: begin
               if (in_byte == 8'hE2) e_done = 1;
               else begin e_err_v = 1; e_code = 3; end
               m_ph = 0;
            end
         endcase
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         logic [20:0] got, exp;
         got = {cmd_valid, cmd_valid ? cmd_byte : 8'h00, pl_valid, pl_valid ? pl_byte : 8'h00,
                done, err_valid, err_code};
         exp = {e_cmd_v, e_cmd_v ? e_cmd : 8'h00, e_pl_v, e_pl_v ? e_pl : 8'h00,
                e_done, e_err_v, e_code};
         checks++;
         if (got !== exp) begin
            errors++;
            $display("FAIL %s at %0t: outputs got %h expected %h", cur_tag, $time, got, exp);
         end
      end
   end

   logic [7:0] pq[$];

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_byte  = 8'h5A;
      end
   endtask

   // build a packet into pq; crc_xor corrupts the check byte
   task automatic build(input logic [7:0] cmd, input int len, input logic [7:0] seed,
                        input logic [7:0] crc_xor, input logic [7:0] t0, input logic [7:0] t1);
      logic [7:0] c;
      pq.delete();
      c = 8'h00;
      pq.push_back(8'hAB); pq.push_back(8'hCD);
      pq.push_back(cmd); c = crc_add(c, cmd);
      pq.push_back(len[7:0]); c = crc_add(c, len[7:0]);
      for (int i = 0; i < len; i++) begin
         logic [7:0] d;
         d = seed + 8'(i * 37);
         pq.push_back(d); c = crc_add(c, d);
      end
      pq.push_back(c ^ crc_xor);
      pq.push_back(t0); pq.push_back(t1);
   endtask

   task automatic send_q(input bit gaps);
      foreach (pq[i]) begin
         send(pq[i]);
         if (gaps && (i % 2 == 1)) idle(2);
      end
      idle(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: quiet outputs in and right after reset
      checks++;
      if ({cmd_valid, pl_valid, done, err_valid, err_code} !== 6'b0) begin
         errors++;
         $display("FAIL R1 reset outputs got %b expected 000000",
                  {cmd_valid, pl_valid, done, err_valid, err_code});
      end
      rst_n = 1'b1;
      cmp_en = 1'b1;
      idle(2);

      cur_tag = "R2 noise then packet";
      send(8'h00); send(8'hCD); send(8'hE2); send(8'h12);
      build(8'h31, 3, 8'h10, 8'h00, 8'hE1, 8'hE2); send_q(0);

      cur_tag = "R4/R5/R9 clean packet";
      build(8'h7E, 6, 8'hA0, 8'h00, 8'hE1, 8'hE2); send_q(0);

      cur_tag = "R3 bad start signature";
      send(8'hAB); send(8'h12); send(8'hCD); idle(2);

      cur_tag = "R3 rearm on repeated 0xAB";
      send(8'hAB);
      build(8'h44, 2, 8'h01, 8'h00, 8'hE1, 8'hE2); send_q(0);

      cur_tag = "R6 zero length";
      build(8'h09, 0, 8'h00, 8'h00, 8'hE1, 8'hE2); send_q(0);

      cur_tag = "R7 corrupt check byte";
      build(8'h22, 4, 8'h33, 8'h01, 8'hE1, 8'hE2); send_q(0);
      build(8'h22, 0, 8'h33, 8'h80, 8'hE1, 8'hE2); send_q(0);

      cur_tag = "R8 wrong first end byte";
      build(8'h55, 2, 8'h70, 8'h00, 8'hE2, 8'hE2); send_q(0);

      cur_tag = "R8 wrong second end byte";
      build(8'h56, 1, 8'h71, 8'h00, 8'hE1, 8'hE1); send_q(0);

      cur_tag = "R10 gaps inside packet";
      build(8'h66, 5, 8'hC3, 8'h00, 8'hE1, 8'hE2); send_q(1);

      cur_tag = "R11 longest payload";
      build(8'hF0, 255, 8'h07, 8'h00, 8'hE1, 8'hE2); send_q(0);

      cur_tag = "R9 back-to-back after error";
      build(8'h01, 1, 8'hFF, 8'h04, 8'hE1, 8'hE2);
      foreach (pq[i]) send(pq[i]);
      build(8'h02, 2, 8'hFE, 8'h00, 8'hE1, 8'hE2); send_q(0);

      idle(4);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule